// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier and Restoring Divider

This block multiplies or divides two unsigned W-bit operands over W clock cycles, one bit per cycle. Multiplication and division share a single datapath. It has three registers: a partial-remainder/high-word register `pReg`, a multiplier/quotient register `aReg` and an operand register `bReg`. One adder/subtractor serves both operations. A multiply shifts the {carry, P, A} chain right after a conditional add. A divide shifts the {P, A} pair left before a trial subtraction.

A client drives `opDiv`, `opA` and `opB` and pulses `start` while the unit is idle. `busy` covers the W iteration cycles. A one-cycle `done` pulse then marks the cycle in which results first become valid. For a multiply, the 2W-bit product is `{resHi, resLo}`. For a divide, the quotient appears on `resLo` and the remainder on `resHi`. A zero divisor raises `divZero`. Results and the flag are held until the next accepted start.

Top module: `muldiv_seq`

## Requirements
- R1: While reset is held and just after it is released, `busy`, `done` and `divZero` are 0, and `resHi` and `resLo` are all zeros.
- R2: When `start` is sampled high with `busy` low, the operation is accepted. `busy` is 1 from the next clock edge. On the W-th rising edge after the accepting edge, `busy` drops to 0 and `done` rises.
- R3: `done` is high for exactly one cycle per accepted operation and is never high together with `busy`.
- R4: With `opDiv`=0 at acceptance, the result at `done` has `{resHi, resLo}` (resHi the upper W bits) equal to opA*opB as unsigned numbers, and `divZero` is 0.
- R5: With `opDiv`=1 and a non-zero `opB`, the result at `done` has `resLo` = floor(opA/opB) and `resHi` = opA mod opB.
- R6: With `opDiv`=1 and `opB`=0, the result at `done` has `divZero`=1, `resLo` all ones and `resHi` equal to opA. The flag clears when the next operation is accepted.
- R7: A `start` sampled while `busy` is 1 is ignored. The running operation keeps its operands, its result and its completion cycle.
- R8: While idle with no start, `resHi`, `resLo` and `divZero` keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin an operation; taken only when idle |
| opDiv | input | 1 | 0 selects multiply, 1 selects divide (sampled with start) |
| opA | input | W | Multiplicand or dividend |
| opB | input | W | Multiplier operand or divisor |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse: results valid |
| divZero | output | 1 | Last divide had a zero divisor |
| resHi | output | W | Product upper half, or remainder |
| resLo | output | W | Product lower half, or quotient |

## Verification
The bound checker watches four things on every cycle:
- every `done` is preceded by exactly W busy cycles;
- `done` is single-cycle and exclusive with `busy`;
- results and the zero-divisor flag hold still while idle;
- the value at `done` is the true product, quotient/remainder or zero-divisor result of the operands captured at acceptance. This last check also shows that starts arriving mid-run are dropped.

Some behaviour only the bench's scenarios can show. These are the exact reset values, and the cycle at which `done` appears relative to a driven `start`. They also include specific arithmetic corners: full-scale operands, a dividend smaller than the divisor, divide by one, and the flag clearing on a following operation.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture operands, clear P
    logic step;   // perform one iteration
  } mdStrobe_t;
endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output mdStrobe_t strobe,
  output logic      busy,
  output logic      done
);
  localparam int CW = $clog2(W) + 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] stepCnt;
  logic          lastStep;

  assign lastStep     = busy && (stepCnt == LAST);
  assign strobe.load  = start && !busy;
  assign strobe.step  = busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      stepCnt <= '0;
    end else begin
      done <= lastStep;
      if (strobe.load) begin
        busy    <= 1'b1;
        stepCnt <= '0;
      end else if (lastStep) begin
        busy    <= 1'b0;
        stepCnt <= '0;
      end else if (busy) begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/muldiv_dp.sv
module muldiv_dp
  import muldiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  mdStrobe_t    strobe,
  input  logic         opDiv,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] resHi,
  output logic [W-1:0] resLo,
  output logic         divZero
);
  localparam int AW = W + 2;   // adder width: sign of trial subtraction visible

  logic [W:0]    pReg;         // one spare bit for the divide path
  logic [W-1:0]  aReg;
  logic [W-1:0]  bReg;
  logic          isDiv;

  logic [W:0]    pShift;
  logic [W-1:0]  aShift;
  logic [AW-1:0] addX, addY, addSum;
  logic          addCin;
  logic          trialNeg;
  logic [W:0]    pNext;
  logic [W-1:0]  aNext;

  // Single shared adder/subtractor
  always_comb begin
    pShift = {pReg[W-1:0], aReg[W-1]};
    aShift = {aReg[W-2:0], 1'b0};
    if (isDiv) begin
      addX   = {1'b0, pShift};
      addY   = ~{2'b00, bReg};
      addCin = 1'b1;
    end else begin
      addX   = {2'b00, pReg[W-1:0]};
      addY   = aReg[0] ? {2'b00, bReg} : '0;
      addCin = 1'b0;
    end
    addSum   = addX + addY + AW'(addCin);
    trialNeg = addSum[AW-1];

    if (isDiv) begin
      pNext = trialNeg ? pShift : addSum[W:0];
      aNext = {aShift[W-1:1], ~trialNeg};
    end else begin
      pNext = {1'b0, addSum[W:1]};
      aNext = {addSum[0], aReg[W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pReg    <= '0;
      aReg    <= '0;
      bReg    <= '0;
      isDiv   <= 1'b0;
      divZero <= 1'b0;
    end else if (strobe.load) begin
      pReg    <= '0;
      aReg    <= opA;
      bReg    <= opB;
      isDiv   <= opDiv;
      divZero <= opDiv && (opB == '0);
    end else if (strobe.step) begin
      pReg <= pNext;
      aReg <= aNext;
    end
  end

  assign resHi = pReg[W-1:0];
  assign resLo = aReg;
endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
  import muldiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         opDiv,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         busy,
  output logic         done,
  output logic         divZero,
  output logic [W-1:0] resHi,
  output logic [W-1:0] resLo
);
  mdStrobe_t strobe;

  muldiv_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .strobe(strobe), .busy(busy), .done(done)
  );

  muldiv_dp #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .opDiv(opDiv), .opA(opA), .opB(opB),
    .resHi(resHi), .resLo(resLo), .divZero(divZero)
  );
endmodule

// File: rtl/muldiv_seq_chk.sv
module muldiv_seq_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         opDiv,
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic         busy,
  input logic         done,
  input logic         divZero,
  input logic [W-1:0] resHi,
  input logic [W-1:0] resLo
);
  logic [W-1:0]   lA, lB;
  logic           lDiv;
  logic           armed;
  int             busyLen;
  logic [2*W-1:0] prodExp;
  logic [W-1:0]   quoExp, remExp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lA <= '0; lB <= '0; lDiv <= 1'b0;
      armed <= 1'b0; busyLen <= 0;
    end else begin
      armed <= 1'b1;
      if (start && !busy) begin
        lA <= opA; lB <= opB; lDiv <= opDiv;
      end
      busyLen <= busy ? busyLen + 1 : 0;
    end
  end

  always_comb begin
    prodExp = {{W{1'b0}}, lA} * {{W{1'b0}}, lB};
    quoExp  = (lB == '0) ? '1 : lA / lB;
    remExp  = (lB == '0) ? lA : lA % lB;
  end

  // R2: exactly W busy cycles precede each done
  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busyLen == W);

  // R3: done is a single-cycle pulse, never with busy
  p_single_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R4 and R7: product matches operands captured at acceptance
  p_mul_r4: assert property (@(posedge clk) disable iff (!rstN)
    done && !lDiv |-> ({resHi, resLo} == prodExp) && !divZero);

  // R5
  p_div_r5: assert property (@(posedge clk) disable iff (!rstN)
    done && lDiv && (lB != '0) |-> (resLo == quoExp) && (resHi == remExp) && !divZero);

  // R6
  p_divzero_r6: assert property (@(posedge clk) disable iff (!rstN)
    done && lDiv && (lB == '0) |-> divZero && (resLo == quoExp) && (resHi == remExp));

  // R8: results held while idle
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(!busy && !start) |-> $stable(resHi) && $stable(resLo) && $stable(divZero));
endmodule

bind muldiv_seq muldiv_seq_chk #(.W(W)) u_chk (.*);

// File: tb/muldiv_seq_bench.sv
module muldiv_seq_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         opDiv = 1'b0;
  logic [W-1:0] opA = '0, opB = '0;
  logic         busy, done, divZero;
  logic [W-1:0] resHi, resLo;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  muldiv_seq #(.W(W)) u_muldiv_seq (
    .clk(clk), .rstN(rstN), .start(start), .opDiv(opDiv),
    .opA(opA), .opB(opB), .busy(busy), .done(done),
    .divZero(divZero), .resHi(resHi), .resLo(resLo)
  );

  // {div, a, b, expHi, expLo, expZero}
  localparam int NV = 10;
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 8'd29,  8'd43,  8'h04, 8'hDF, 1'b0},
    {1'b0, 8'd255, 8'd255, 8'hFE, 8'h01, 1'b0},
    {1'b0, 8'd0,   8'd200, 8'h00, 8'h00, 1'b0},
    {1'b0, 8'd9,   8'd5,   8'h00, 8'h2D, 1'b0},
    {1'b1, 8'd200, 8'd7,   8'h04, 8'h1C, 1'b0},
    {1'b1, 8'd255, 8'd1,   8'h00, 8'hFF, 1'b0},
    {1'b1, 8'd5,   8'd9,   8'h05, 8'h00, 1'b0},
    {1'b1, 8'd100, 8'd0,   8'h64, 8'hFF, 1'b1},
    {1'b1, 8'd255, 8'd255, 8'h00, 8'h01, 1'b0},
    {1'b1, 8'd128, 8'd16,  8'h00, 8'h08, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue one operation and wait for done; returns negedges counted to done
  task automatic runOp(input logic d, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic midStart, output int lat);
    lat = 0;
    @(negedge clk);
    start = 1'b1; opDiv = d; opA = a; opB = b;
    for (int i = 1; i <= W + 3; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (i == 1) chk("R2 busy after start", busy, 1);
      if (midStart && i == 2) begin
        // R7: disruptive start while busy
        start = 1'b1; opDiv = ~d; opA = 8'hAA; opB = 8'h03;
      end
      if (done && lat == 0) lat = i;
      if (lat != 0) break;
    end
    start = 1'b0;
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 divZero", divZero, 0);
    chk("R1 result", {resHi, resLo}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", {busy, done, divZero, resHi, resLo}, 0);

    for (int v = 0; v < NV; v++) begin
      runOp(VEC[v][33], VEC[v][32:25], VEC[v][24:17], 1'b0, lat);
      chk("R2 latency", lat, W + 1);
      if (VEC[v][33]) begin
        chk("R5 remainder", resHi, VEC[v][16:9]);
        chk("R5 quotient", resLo, VEC[v][8:1]);
      end else begin
        chk("R4 product", {resHi, resLo}, {VEC[v][16:9], VEC[v][8:1]});
      end
      chk("R6 divZero flag", divZero, VEC[v][0]);
      @(negedge clk);
      chk("R3 done single", done, 0);
      chk("R8 hold hi", resHi, VEC[v][16:9]);
      chk("R8 hold lo", resLo, VEC[v][8:1]);
    end

    // R6: flag clears on the next accepted operation
    runOp(1'b1, 8'd77, 8'd0, 1'b0, lat);
    chk("R6 flag set", divZero, 1);
    chk("R6 remainder is dividend", resHi, 8'd77);
    runOp(1'b0, 8'd3, 8'd4, 1'b0, lat);
    chk("R6 flag cleared", divZero, 0);

    // R7: start during busy ignored
    runOp(1'b0, 8'd12, 8'd11, 1'b1, lat);
    chk("R7 latency unchanged", lat, W + 1);
    chk("R7 product kept", {resHi, resLo}, 16'd132);
    @(negedge clk);
    chk("R7 no second run", busy, 0);
    repeat (W + 2) @(negedge clk);
    chk("R7 no extra done", done, 0);
    chk("R8 long hold", {resHi, resLo}, 16'd132);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule